// File: doc/BRIEF.md
# Seeded Frame Scrambler

This block whitens the bit stream of a frame so that the line carries enough transitions for clock recovery. Each data bit leaving the block is the input bit XOR-ed with the output of a 15-stage linear feedback shift register whose taps realise the polynomial 1 + D^14 + D^15. At every frame boundary the register is reloaded from one of four fixed seeds, and the 2-bit identifier that picks the seed is exported so a header builder can place it in the frame header.

In transmit direction the identifier comes from an internal 2-bit counter that wraps and advances once per frame. In receive direction the same core descrambles: the identifier is supplied from the decoded header of the incoming frame, the matching seed is loaded, and the counter is left untouched. Fields that must travel in clear (preamble, PHY header) are sent with the bypass input raised, which passes bits unchanged and freezes the register. Data moves with a valid/ready handshake that adds no storage: the block is a combinational stage between producer and consumer.

Top module: `frame_scrambler`

## Requirements
- R1: After reset the exported identifier `seed_id_o` is 0 and no output transfer is offered while `in_valid` is low.
- R2: In transmit direction (`rx_mode`=0) a `frame_start` pulse makes `seed_id_o` take the counter value from the next cycle on; the counter then advances by one, modulo 4, so successive frames use identifiers 0,1,2,3,0,...
- R3: In receive direction (`rx_mode`=1) a `frame_start` pulse makes `seed_id_o` equal `rx_seed_id` and does not advance the transmit counter.
- R4: On `frame_start` the register is loaded with the seed for the selected identifier: a 15-bit value whose two leftmost bits are the identifier (MSB first) and whose remaining 13 bits are ones; the leftmost bit goes into the first delay stage.
- R5: Each sequence bit is the XOR of the contents of delay stages 14 and 15; after each scrambled transfer that bit enters stage 1 and every other stage takes the value of the stage before it. The first bit after a load is combined with the first data bit.
- R6: With `bypass`=0, `out_data` equals `in_data` XOR the current sequence bit.
- R7: With `bypass`=1, `out_data` equals `in_data` and a transfer leaves the register unchanged, so the sequence resumes where it paused.
- R8: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, except in a `frame_start` cycle, where both are 0; the register advances only on a completed transfer.
- R9: A `frame_start` in the middle of a frame restarts the sequence from the newly selected seed.
- R10: Feeding the scrambled output of a frame back in receive direction with the same identifier reproduces the original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that reloads the seed |
| rx_mode | input | 1 | 0 = transmit (counter identifier), 1 = receive (header identifier) |
| rx_seed_id | input | 2 | Identifier decoded from a received header |
| bypass | input | 1 | Pass data unchanged and hold the register |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Input bit accepted |
| in_data | input | 1 | Input bit |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 1 | Scrambled or passed-through bit |
| seed_id_o | output | 2 | Identifier in use for the current frame |

## Verification
The bench walks the identifier counter through its wrap from 3 back to 0, where a counter of the wrong width or one advanced on receive frames would send the wrong seed. Clear-text runs placed inside a scrambled stretch catch a register that keeps shifting during bypass, which would misalign every later bit, and a stalled consumer catches a register that advances on valid alone. A restart in mid-frame and a full receive-side round trip show whether the seed bit order and tap positions are right; a reversed seed or a wrong tap yields a different stream from the first few bits on.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned SCR_LEN   = 15;
  localparam int unsigned SCR_TAP_A = 14;
  localparam int unsigned SCR_TAP_B = 15;
  localparam int unsigned SCR_ID_W  = 2;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } scr_dir_e;
endpackage

// File: rtl/scr_seed_sel.sv
module scr_seed_sel #(
  parameter int unsigned LEN  = scr_pkg::SCR_LEN,
  parameter int unsigned ID_W = scr_pkg::SCR_ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rx_mode,
  input  logic [ID_W-1:0] rx_id,
  output logic [ID_W-1:0] id_o,
  output logic [LEN-1:0]  seed_o
);
  localparam int unsigned NUM_IDS = 1 << ID_W;

  logic [LEN-1:0]  seed_tbl [NUM_IDS];
  logic [ID_W-1:0] cnt_q, cnt_d;
  logic [ID_W-1:0] id_q, id_d;
  logic [ID_W-1:0] sel_id;

  // seed: identifier in the leftmost bits (stage 1 = bit 0), ones elsewhere
  for (genvar g = 0; g < NUM_IDS; g++) begin : g_tbl
    localparam logic [ID_W-1:0] GID = ID_W'(g);
    for (genvar b = 0; b < LEN; b++) begin : g_bit
      if (b < ID_W) begin : g_id
        assign seed_tbl[g][b] = GID[ID_W-1-b];
      end else begin : g_one
        assign seed_tbl[g][b] = 1'b1;
      end
    end
  end

  always_comb begin
    sel_id = (rx_mode == scr_pkg::DIR_RX) ? rx_id : cnt_q;
    seed_o = seed_tbl[sel_id];
    cnt_d  = cnt_q;
    id_d   = id_q;
    if (start) begin
      id_d = sel_id;
      if (rx_mode == scr_pkg::DIR_TX) begin
        cnt_d = cnt_q + ID_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      id_q  <= '0;
    end else if (start) begin
      cnt_q <= cnt_d;
      id_q  <= id_d;
    end
  end

  assign id_o = id_q;

  AST_TX_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rx_mode) |=> (id_o == $past(cnt_q)) && (cnt_q == $past(cnt_q) + ID_W'(1))); // R2
  AST_RX_ID_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rx_mode) |=> (id_o == $past(rx_id)) && $stable(cnt_q)); // R3
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(id_o)); // R2
endmodule

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
  parameter int unsigned LEN   = scr_pkg::SCR_LEN,
  parameter int unsigned TAP_A = scr_pkg::SCR_TAP_A,
  parameter int unsigned TAP_B = scr_pkg::SCR_TAP_B
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LEN-1:0] seed,
  input  logic           adv,
  output logic           seq_o
);
  // state[k-1] holds delay stage k
  logic [LEN-1:0] state_q, state_d;
  logic           fb;
  logic           en;

  always_comb begin
    fb      = state_q[TAP_A-1] ^ state_q[TAP_B-1];
    en      = load | adv;
    state_d = state_q;
    if (load) begin
      state_d = seed;
    end else if (adv) begin
      state_d = {state_q[LEN-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (en) begin
      state_q <= state_d;
    end
  end

  assign seq_o = fb;

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state_q == $past(seed)); // R4
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (state_q[0] == $past(seq_o)) && (state_q[LEN-1:1] == $past(state_q[LEN-2:0]))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(state_q)); // R7
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler #(
  parameter int unsigned LEN   = scr_pkg::SCR_LEN,
  parameter int unsigned TAP_A = scr_pkg::SCR_TAP_A,
  parameter int unsigned TAP_B = scr_pkg::SCR_TAP_B,
  parameter int unsigned ID_W  = scr_pkg::SCR_ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            rx_mode,
  input  logic [ID_W-1:0] rx_seed_id,
  input  logic            bypass,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_data,
  output logic [ID_W-1:0] seed_id_o
);
  logic           rst_meta_q, rst_sync_q;
  logic [LEN-1:0] seed;
  logic           seq_bit;
  logic           fire;
  logic           adv;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    in_ready  = out_ready & ~frame_start;
    out_valid = in_valid & ~frame_start;
    fire      = in_valid & in_ready;
    adv       = fire & ~bypass;
    out_data  = bypass ? in_data : (in_data ^ seq_bit);
  end

  scr_seed_sel #(.LEN(LEN), .ID_W(ID_W)) i_seed_sel (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start   (frame_start),
    .rx_mode (rx_mode),
    .rx_id   (rx_seed_id),
    .id_o    (seed_id_o),
    .seed_o  (seed)
  );

  scr_lfsr #(.LEN(LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) i_lfsr (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .load  (frame_start),
    .seed  (seed),
    .adv   (adv),
    .seq_o (seq_bit)
  );

  AST_NO_XFER_ON_START: assert property (@(posedge clk) disable iff (!rst_sync_q)
    frame_start |-> (!in_ready && !out_valid)); // R8
  AST_BYPASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bypass && out_valid) |-> (out_data == in_data)); // R7
  AST_READY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !frame_start |-> (in_ready == out_ready) && (out_valid == in_valid)); // R8
endmodule

// File: tb/test_frame_scrambler.sv
module test_frame_scrambler;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_start, rx_mode, bypass, in_valid, in_data, out_ready;
  logic [1:0] rx_seed_id;
  logic       in_ready, out_valid, out_data;
  logic [1:0] seed_id_o;

  int unsigned checks = 0;
  int unsigned errors = 0;

  logic  exp_q[$];
  string tag_q[$];
  logic  cap_q[$];

  logic [15:1] h;      // h[k] = sequence bit k positions back
  logic [1:0]  m_cnt;

  always #(CLK_P/2) clk = ~clk;

  frame_scrambler i_frame_scrambler (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_mode(rx_mode),
    .rx_seed_id(rx_seed_id), .bypass(bypass), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .seed_id_o(seed_id_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  // monitor: compares each output transfer against the scoreboard
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && out_valid && out_ready) begin
      cap_q.push_back(out_data);
      if (exp_q.size() == 0) begin
        check("R8 unexpected output", 32'(out_data), 32'hx);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(out_data), 32'(e));
      end
    end
  end

  function automatic logic model_bit(input logic d, input logic byp);
    logic x;
    if (byp) return d;
    x = h[14] ^ h[15];
    h = {h[14:1], x};
    return d ^ x;
  endfunction

  task automatic start_frame(input logic rx, input logic [1:0] rid, input string tag);
    logic [1:0] id;
    @(negedge clk);
    in_valid = 1'b1; in_data = 1'b0; bypass = 1'b0;
    frame_start = 1'b1; rx_mode = rx; rx_seed_id = rid;
    #(CLK_P/4);
    check("R8 in_ready low on frame_start", 32'(in_ready), 32'd0);
    check("R8 out_valid low on frame_start", 32'(out_valid), 32'd0);
    if (rx) id = rid; else begin id = m_cnt; m_cnt = m_cnt + 2'd1; end
    h = '1; h[1] = id[1]; h[2] = id[0];
    @(negedge clk);
    frame_start = 1'b0; in_valid = 1'b0;
    #(CLK_P/4);
    check(tag, 32'(seed_id_o), 32'(id));
  endtask

  task automatic xfer(input logic d, input logic byp, input string tag);
    exp_q.push_back(model_bit(d, byp));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; bypass = byp;
    do @(posedge clk); while (!in_ready);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; bypass = 1'b0;
  endtask

  initial begin
    logic sent[$];
    logic [1:0] rt_id;
    rst_n = 1'b0; frame_start = 1'b0; rx_mode = 1'b0; rx_seed_id = 2'd0;
    bypass = 1'b0; in_valid = 1'b0; in_data = 1'b0; out_ready = 1'b1;
    h = '0; m_cnt = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    check("R1 seed_id after reset", 32'(seed_id_o), 32'd0);
    check("R1 out_valid idle", 32'(out_valid), 32'd0);

    // frame with id 0: clear header, scrambled zeros, pattern, clear gap
    start_frame(1'b0, 2'd0, "R2 first frame id");
    for (int i = 0; i < 8; i++) xfer(1'(i % 3 == 0), 1'b1, "R7 clear header bit");
    for (int i = 0; i < 24; i++) xfer(1'b0, 1'b0, "R4 R5 sequence bit");
    for (int i = 0; i < 12; i++) xfer(1'((i * 5 + 1) % 7 > 3), 1'b0, "R6 data xor sequence");
    for (int i = 0; i < 5; i++) xfer(1'(i[0]), 1'b1, "R7 bypass mid frame");
    for (int i = 0; i < 12; i++) xfer(1'((i * 3) % 5 > 1), 1'b0, "R7 sequence resumes");
    idle();

    // identifier walk through the wrap
    for (int f = 0; f < 4; f++) begin
      start_frame(1'b0, 2'd0, "R2 identifier advance and wrap");
      for (int i = 0; i < 20; i++) xfer(1'b0, 1'b0, "R4 seed specific sequence");
      idle();
    end

    // consumer stall does not advance the register
    start_frame(1'b0, 2'd0, "R2 id before stall test");
    for (int i = 0; i < 4; i++) xfer(1'b1, 1'b0, "R6 before stall");
    exp_q.push_back(model_bit(1'b1, 1'b0));
    tag_q.push_back("R8 bit after stall");
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 1'b1; bypass = 1'b0;
    #(CLK_P/4);
    check("R8 in_ready follows out_ready", 32'(in_ready), 32'd0);
    check("R8 out_valid follows in_valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    @(negedge clk);
    out_ready = 1'b1;
    do @(posedge clk); while (!in_ready);
    for (int i = 0; i < 6; i++) xfer(1'b0, 1'b0, "R8 sequence after stall");
    // restart mid frame
    start_frame(1'b0, 2'd0, "R9 restart id");
    for (int i = 0; i < 18; i++) xfer(1'b0, 1'b0, "R9 sequence after restart");
    idle();

    // round trip: transmit, then descramble with the received identifier
    rt_id = m_cnt;
    start_frame(1'b0, 2'd0, "R2 round trip tx id");
    cap_q.delete();
    for (int i = 0; i < 30; i++) begin
      logic d;
      d = 1'((i * 7 + 3) % 11 > 5);
      sent.push_back(d);
      xfer(d, 1'b0, "R6 round trip tx");
    end
    idle();
    start_frame(1'b1, rt_id, "R3 rx identifier taken");
    for (int i = 0; i < 30; i++) begin
      logic enc;
      enc = cap_q[i];
      void'(model_bit(1'b0, 1'b0));
      exp_q.push_back(sent[i]);
      tag_q.push_back("R10 descrambled data");
      @(negedge clk);
      in_valid = 1'b1; in_data = enc; bypass = 1'b0;
      do @(posedge clk); while (!in_ready);
    end
    idle();
    rx_mode = 1'b0;
    start_frame(1'b0, 2'd0, "R3 counter untouched by rx frame");
    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule